// File: doc/BRIEF.md
# Programmable Address Window Decoder with Remap

This block compares a 32-bit CPU address against a bank of programmable address windows and reports which window, if any, claims it. Each window holds a control word (enable, size mask, target code, attribute), a base, a low remap word and a high remap word. A lookup is issued with `lk_valid` and `lk_addr`. One clock later the block returns a hit or no-hit flag, the winning window index, its target and attribute, and the translated address.

A window's size is a 16-bit mask counted in 64 KB pages. Normally it is a run of ones starting at bit 0. Each one doubles the window, and an all-zero mask still covers one 64 KB page. Address bits under zero mask bits must equal the base. On a hit those bits are replaced by the window's remap value. Software that does not want translation writes the low remap word equal to the base. Windows left out of the `REMAP_WIN` parameter have no remap storage. Addresses that hit them pass through untranslated.

A simple write/read port programs the registers. The window is selected by `cfg_win` and the register by `cfg_sel`.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every window is disabled, every register reads zero, and a lookup reports no-hit.
- R2: Control word layout: bit 0 is enable, bits [7:4] are the target, bits [15:8] are the attribute and bits [31:16] are the size mask. `cfg_sel` selects 0=control, 1=base, 2=low remap, 3=high remap. Writes take effect at the clock edge where `cfg_we` is high.
- R3: An address hits a window when the window is enabled and `lk_addr[31:16]` equals `base[31:16]` on every bit where the size mask is zero. Size 0x0000 covers exactly 64 KB and size 0x00FF covers 16 MB.
- R4: On a hit, translated address bits [31:16] come from the low remap word where the mask is zero, and from `lk_addr` where the mask is one. Bits [15:0] always come from `lk_addr`.
- R5: A window whose low remap word equals its base returns the incoming address unchanged.
- R6: In a window outside `REMAP_WIN`, writes to either remap register are ignored and both read back as zero. A hit there returns the incoming address unchanged.
- R7: When several windows hit, the lowest-numbered one is reported.
- R8: A miss sets `rsp_nohit`, clears `rsp_hit`, drives window index, target and attribute to zero, and passes the address through unchanged.
- R9: A size mask that is not a run of ones from bit 0 is stored as written and applied bit by bit, both for matching and for translation.
- R10: The lookup result appears with `rsp_valid` exactly one cycle after `lk_valid`. `rsp_valid` is low in cycles that follow no request.
- R11: `cfg_rdata` shows the selected register one cycle after selection. Base and low remap read back with bits [15:0] zero. The high remap word of a remap-capable window reads back all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 3 | Window index for write and read |
| cfg_sel | input | 2 | Register select: 0 control, 1 base, 2 low remap, 3 high remap |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data of the selected register |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_nohit | output | 1 | Valid result with no matching window |
| rsp_win | output | 3 | Winning window index |
| rsp_tgt | output | 4 | Target of the winning window |
| rsp_attr | output | 8 | Attribute of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
The bench builds the decoder with its defaults: eight windows, with remap storage on windows 0 to 4 only. This mix puts both kinds of window in one run. Writes to remap registers of a window without remap can be shown to vanish, while a remap window can be used to show a broken size mask acting bit by bit on the translated address. Overlapping windows 0 and 3 test priority, first with both enabled and then with window 0 switched off. The 64 KB and 16 MB sizes are probed one page inside and one page outside their edges.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ADDR_W = 32;
  localparam int PAGE_W = 16;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;
  localparam int PAD_W  = ADDR_W - HI_W - ATTR_W - TGT_W - 1;

  typedef struct packed {
    logic [HI_W-1:0]   size;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  tgt;
    logic [PAD_W-1:0]  pad;
    logic              en;
  } win_ctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RMLO = 2'd2,
    SEL_RMHI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter logic [NUM_WIN-1:0] REMAP_WIN = '1,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_W-1:0]    win,
  input  logic [1:0]          sel,
  input  logic [ADDR_W-1:0]   wdata,
  output logic [ADDR_W-1:0]   rdata,
  output win_ctrl_t           ctrl    [NUM_WIN],
  output logic [HI_W-1:0]     base_hi [NUM_WIN],
  output logic [HI_W-1:0]     rmap_hi [NUM_WIN],
  output logic [NUM_WIN-1:0]  en_vec
);
  logic [ADDR_W-1:0] rmword [NUM_WIN];
  logic [HI_W-1:0]   rmlo_rd [NUM_WIN];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic hit_w;
    assign hit_w = we && (win == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl[i]    <= '0;
        base_hi[i] <= '0;
      end else if (hit_w) begin
        if (sel == SEL_CTRL) ctrl[i] <= win_ctrl_t'(wdata);
        if (sel == SEL_BASE) base_hi[i] <= wdata[ADDR_W-1:PAGE_W];
      end
    end
    assign en_vec[i] = ctrl[i].en;

    if (REMAP_WIN[i]) begin : g_remap
      logic [HI_W-1:0]   lo_q;
      logic [ADDR_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (hit_w) begin
          if (sel == SEL_RMLO) lo_q <= wdata[ADDR_W-1:PAGE_W];
          if (sel == SEL_RMHI) hi_q <= wdata;
        end
      end
      assign rmap_hi[i] = lo_q;
      assign rmlo_rd[i] = lo_q;
      assign rmword[i]  = hi_q;
    end else begin : g_plain
      // translation of a plain window reuses its base, so hits pass through
      assign rmap_hi[i] = base_hi[i];
      assign rmlo_rd[i] = '0;
      assign rmword[i]  = '0;
    end
  end

  logic [ADDR_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (int'(win) < NUM_WIN) begin
      case (reg_sel_e'(sel))
        SEL_CTRL: rd_mux = ADDR_W'(ctrl[win]);
        SEL_BASE: rd_mux = {base_hi[win], {PAGE_W{1'b0}}};
        SEL_RMLO: rd_mux = {rmlo_rd[win], {PAGE_W{1'b0}}};
        default:  rd_mux = rmword[win];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R1
  reset_disables_chk: assert property (@(posedge clk) rst |=> (en_vec == '0));
  // R6
  plain_rmlo_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_RMLO && int'(win) < NUM_WIN && !REMAP_WIN[win]) |=> (rdata == '0));
endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic [HI_W-1:0]    addr_hi,
  input  win_ctrl_t          ctrl    [NUM_WIN],
  input  logic [HI_W-1:0]    base_hi [NUM_WIN],
  input  logic [HI_W-1:0]    rmap_hi [NUM_WIN],
  output logic [NUM_WIN-1:0] hit_vec,
  output logic [HI_W-1:0]    xlat_hi [NUM_WIN]
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic [HI_W-1:0] diff;
    assign diff       = (addr_hi ^ base_hi[i]) & ~ctrl[i].size;
    assign hit_vec[i] = ctrl[i].en && (diff == '0);
    assign xlat_hi[i] = (rmap_hi[i] & ~ctrl[i].size) | (addr_hi & ctrl[i].size);
  end
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int NUM_WIN = 8,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter logic [NUM_WIN-1:0] REMAP_WIN = 8'h1F,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_win,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_nohit,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [TGT_W-1:0]  rsp_tgt,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic [ADDR_W-1:0] rsp_addr
);
  win_ctrl_t          ctrl    [NUM_WIN];
  logic [HI_W-1:0]    base_hi [NUM_WIN];
  logic [HI_W-1:0]    rmap_hi [NUM_WIN];
  logic [HI_W-1:0]    xlat_hi [NUM_WIN];
  logic [NUM_WIN-1:0] en_vec;
  logic [NUM_WIN-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;

  awd_regs #(.NUM_WIN(NUM_WIN), .REMAP_WIN(REMAP_WIN)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .win(cfg_win), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl(ctrl), .base_hi(base_hi),
    .rmap_hi(rmap_hi), .en_vec(en_vec)
  );

  awd_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr_hi(lk_addr[ADDR_W-1:PAGE_W]), .ctrl(ctrl), .base_hi(base_hi),
    .rmap_hi(rmap_hi), .hit_vec(hit_vec), .xlat_hi(xlat_hi)
  );

  awd_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_nohit <= 1'b0;
      rsp_win   <= '0;
      rsp_tgt   <= '0;
      rsp_attr  <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit;
      rsp_nohit <= lk_valid && !any_hit;
      if (lk_valid) begin
        rsp_win  <= any_hit ? win_idx : '0;
        rsp_tgt  <= any_hit ? ctrl[win_idx].tgt : '0;
        rsp_attr <= any_hit ? ctrl[win_idx].attr : '0;
        rsp_addr <= any_hit ? {xlat_hi[win_idx], lk_addr[PAGE_W-1:0]} : lk_addr;
      end
    end
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  // R8
  miss_zero_fields_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_nohit |-> (rsp_tgt == '0 && rsp_attr == '0 && rsp_win == '0 && !rsp_hit));
  // R8
  miss_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_nohit |-> (rsp_addr == $past(lk_addr)));
  // R4
  page_offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_addr[PAGE_W-1:0] == $past(lk_addr[PAGE_W-1:0])));
  // R7
  winner_hits_chk: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (hit_vec[win_idx] &&
                 ((hit_vec & ((NUM_WIN'(1) << win_idx) - NUM_WIN'(1))) == '0)));
  // R3
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ((hit_vec & ~en_vec) == '0));
endmodule

// File: tb/sim_addr_win_decoder.sv
module sim_addr_win_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_nohit;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_tgt;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_win_decoder u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_nohit(rsp_nohit), .rsp_win(rsp_win), .rsp_tgt(rsp_tgt),
    .rsp_attr(rsp_attr), .rsp_addr(rsp_addr)
  );

  function automatic logic [31:0] mk_ctrl(logic [15:0] size, logic [7:0] attr,
                                          logic [3:0] tgt, logic en);
    return {size, attr, tgt, 3'b000, en};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int w, int s, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 3'(w); cfg_sel = 2'(s); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(int w, int s, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_win = 3'(w); cfg_sel = 2'(s);
    @(negedge clk);
    chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic look(logic [31:0] a, logic hit, int w, logic [3:0] t,
                      logic [7:0] at, logic [31:0] xa, string tag);
    logic [50:0] act, exp;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    act = {rsp_valid, rsp_hit, rsp_nohit, rsp_win, rsp_tgt, rsp_attr, rsp_addr};
    exp = {1'b1, hit, !hit, 3'(w), t, at, xa};
    chk(act == exp, tag, 64'(act), 64'(exp));
  endtask

  // R1
  task automatic t_reset();
    for (int w = 0; w < 8; w++) rd_chk(w, 0, 32'h0, "R1 ctrl after reset");
    rd_chk(0, 3, 32'h0, "R1 remap high after reset");
    look(32'h1234_5678, 0, 0, 0, 0, 32'h1234_5678, "R1 lookup after reset misses");
  endtask

  // R2 R3 R5 R8: 256 MB window with remap equal to base
  task automatic t_plain_window();
    wr(0, 0, mk_ctrl(16'h0FFF, 8'hE8, 4'h1, 1'b1));
    wr(0, 1, 32'h9000_0000);
    wr(0, 2, 32'h9000_0000);
    rd_chk(0, 0, 32'h0FFF_E811, "R2 control readback");
    look(32'h9ABC_DEF0, 1, 0, 4'h1, 8'hE8, 32'h9ABC_DEF0, "R5 identity remap");
    look(32'hA000_0000, 0, 0, 0, 0, 32'hA000_0000, "R8 miss above window");
  endtask

  // R3 R4: 64 KB window translated to zero
  task automatic t_small_remap();
    wr(1, 0, mk_ctrl(16'h0000, 8'hE0, 4'h2, 1'b1));
    wr(1, 1, 32'hC001_0000);
    wr(1, 2, 32'h0000_0000);
    look(32'hC001_1234, 1, 1, 4'h2, 8'hE0, 32'h0000_1234, "R4 64KB remap");
    look(32'hC002_0000, 0, 0, 0, 0, 32'hC002_0000, "R3 64KB upper edge");
    look(32'hC000_FFFF, 0, 0, 0, 0, 32'hC000_FFFF, "R3 64KB lower edge");
  endtask

  // R3 R4: 16 MB window
  task automatic t_16mb();
    wr(2, 0, mk_ctrl(16'h00FF, 8'h5A, 4'h7, 1'b1));
    wr(2, 1, 32'hD000_0000);
    wr(2, 2, 32'hE000_0000);
    look(32'hD0AB_CDEF, 1, 2, 4'h7, 8'h5A, 32'hE0AB_CDEF, "R4 16MB remap");
    look(32'hD0FF_0000, 1, 2, 4'h7, 8'h5A, 32'hE0FF_0000, "R3 16MB last page");
    look(32'hD100_0000, 0, 0, 0, 0, 32'hD100_0000, "R3 16MB past end");
  endtask

  // R7: window 3 overlaps window 0
  task automatic t_priority();
    wr(3, 0, mk_ctrl(16'h0FFF, 8'h33, 4'h3, 1'b1));
    wr(3, 1, 32'h9000_0000);
    wr(3, 2, 32'h9000_0000);
    look(32'h9000_0040, 1, 0, 4'h1, 8'hE8, 32'h9000_0040, "R7 lowest index wins");
    wr(0, 0, mk_ctrl(16'h0FFF, 8'hE8, 4'h1, 1'b0));
    look(32'h9000_0040, 1, 3, 4'h3, 8'h33, 32'h9000_0040, "R7 next window after disable");
  endtask

  // R6: window 5 has no remap storage
  task automatic t_plain_only();
    wr(5, 2, 32'h1234_0000);
    wr(5, 3, 32'hCAFE_F00D);
    rd_chk(5, 2, 32'h0, "R6 low remap ignored");
    rd_chk(5, 3, 32'h0, "R6 high remap ignored");
    wr(5, 0, mk_ctrl(16'h0000, 8'h1D, 4'h5, 1'b1));
    wr(5, 1, 32'hF000_0000);
    look(32'hF000_4321, 1, 5, 4'h5, 8'h1D, 32'hF000_4321, "R6 plain window passthrough");
  endtask

  // R9: mask with only bit 8 set
  task automatic t_broken_mask();
    wr(4, 0, mk_ctrl(16'h0100, 8'h44, 4'h4, 1'b1));
    wr(4, 1, 32'h4000_0000);
    wr(4, 2, 32'h2000_0000);
    rd_chk(4, 0, 32'h0100_4441, "R9 mask stored as written");
    look(32'h4100_0010, 1, 4, 4'h4, 8'h44, 32'h2100_0010, "R9 masked bit from address");
    look(32'h4000_0010, 1, 4, 4'h4, 8'h44, 32'h2000_0010, "R9 unmasked bit from remap");
    look(32'h4001_0000, 0, 0, 0, 0, 32'h4001_0000, "R9 low page bit not masked");
  endtask

  // R11 R10
  task automatic t_readback();
    wr(1, 1, 32'hC001_ABCD);
    rd_chk(1, 1, 32'hC001_0000, "R11 base low bits read zero");
    wr(1, 3, 32'hDEAD_BEEF);
    rd_chk(1, 3, 32'hDEAD_BEEF, "R11 high remap word");
    rd_chk(2, 2, 32'hE000_0000, "R11 low remap readback");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 no result without request", 64'(rsp_valid), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain_window();
    t_small_remap();
    t_16mb();
    t_priority();
    t_plain_only();
    t_broken_mask();
    t_readback();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule